// File: doc/BRIEF.md
# Direct-mapped write-through data cache

This block sits between a 32-bit byte-addressed processor and main memory. It keeps 4096 lines of four 32-bit words each (64 KB of data). Every line has a single possible home, chosen by the middle address bits. A per-line tag and valid flag decide whether an access hits. Read hits return the addressed word in the same cycle. A miss stalls the processor while the whole block is fetched from memory, one word per acknowledge.

Writes always go through to memory. A write to a resident block updates both the line and memory, and the processor is released only when memory acknowledges the write. A write to an absent block first refills the whole block, and then applies the word to the line and to memory.

The memory port is a plain request/acknowledge interface. The cache holds address, direction and data steady while the request waits for its acknowledge.

Top module: `dm_wt_cache`

## Requirements
- R1: The address splits into tag = bits 31:16, line index = bits 15:4, word select = bits 3:2 and byte offset = bits 1:0. Two addresses that share an index but differ in tag occupy the same line.
- R2: After reset every line is invalid, `cpu_stall_o` and `mem_req_o` are low, and the first access to any line misses.
- R3: A read hits only when the line is valid and its tag equals the address tag. A read hit completes with `cpu_stall_o` low in the request cycle and raises no memory request.
- R4: Bits 3:2 of the address pick which of the four words of the line appears on `cpu_rdata_o`.
- R5: A read miss fetches the block with four memory reads at word addresses {tag, index, k, 2'b00}, in the order k = 0, 1, 2, 3. Stall stays high until the requested word is returned.
- R6: The line's valid flag is cleared when a refill starts and set only after the fourth word is stored, together with the new tag. A refill evicts the previous occupant of the line.
- R7: Every write raises a memory write (`mem_we_o` = 1) at the word-aligned address carrying `cpu_wdata_i`. Stall stays high until that write is acknowledged.
- R8: A write miss refills the whole block first. The other three words of the line then hold memory's contents, and the written word holds the new data.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, the memory address, direction and write data stay stable.
- R10: Byte offset bits 1:0 have no effect on hit detection or on the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request, held until stall is low |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Read data, valid when stall is low |
| cpu_stall_o | output | 1 | Processor must hold its request |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one per word |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |

## Verification
The hardest case to reach is a write that misses. The whole block must be fetched first, and the new word must then be merged into the line and sent to memory. Afterwards the untouched neighbours must still read memory's original values. The stimulus targets an index that has never been used, writes one word there, and counts memory reads and writes. It then reads a sibling word, which must now hit, and the written word. Eviction is reached by a read to the same index with a different tag, followed by a read of the original address, which must miss again.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE
  } cache_state_e;
endpackage

// File: rtl/cache_word_sel.sv
module cache_word_sel #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic [WORDS-1:0][DATA_W-1:0] line_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [DATA_W-1:0]            word_o
);
  logic [WORDS-1:0][DATA_W-1:0] masked;

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign masked[g] = (sel_i == SEL_W'(g)) ? line_i[g] : '0;
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < WORDS; k++) word_o = word_o | masked[k];
  end
endmodule

// File: rtl/cache_store.sv
module cache_store #(
  parameter int IDX_W  = 12,
  parameter int TAG_W  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic                         fill_start_i,
  input  logic                         fill_wr_i,
  input  logic                         fill_last_i,
  input  logic [SEL_W-1:0]             fill_sel_i,
  input  logic [DATA_W-1:0]            fill_data_i,
  input  logic                         wr_commit_i,
  input  logic [SEL_W-1:0]             wr_sel_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic                         hit_o,
  output logic [WORDS-1:0][DATA_W-1:0] line_o
);
  logic [LINES-1:0]             valid_q;
  logic [TAG_W-1:0]             tag_q  [LINES];
  logic [WORDS-1:0][DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (fill_start_i) valid_q[idx_i] <= 1'b0;
    else if (fill_last_i) valid_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_last_i) tag_q[idx_i] <= tag_i;
    if (fill_wr_i) data_q[idx_i][fill_sel_i] <= fill_data_i;
    else if (wr_commit_i) data_q[idx_i][wr_sel_i] <= wr_data_i;
  end

  assign hit_o  = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign line_o = data_q[idx_i];

  // R6
  fill_clears_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_start_i |=> !valid_q[$past(idx_i)]);
  // R6
  fill_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_last_i |=> valid_q[$past(idx_i)]);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic             hit_i,
  input  logic             mem_ack_i,
  output logic             stall_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             fill_phase_o,
  output logic [SEL_W-1:0] fill_sel_o,
  output logic             fill_start_o,
  output logic             fill_wr_o,
  output logic             fill_last_o,
  output logic             wr_commit_o
);
  cache_state_e     state_q, state_d;
  logic [SEL_W-1:0] cnt_q, cnt_d;
  logic             cnt_end;

  assign cnt_end = (cnt_q == SEL_W'(WORDS - 1));

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    fill_start_o = 1'b0;
    fill_wr_o    = 1'b0;
    fill_last_o  = 1'b0;
    wr_commit_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_i && !hit_i) begin
          state_d      = ST_FILL;
          cnt_d        = '0;
          fill_start_o = 1'b1;
        end else if (cpu_req_i && cpu_we_i) begin
          state_d = ST_WRITE;
        end
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          fill_wr_o = 1'b1;
          cnt_d     = cnt_q + 1'b1;
          if (cnt_end) begin
            fill_last_o = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack_i) begin
          wr_commit_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mem_req_o    = (state_q != ST_IDLE);
  assign mem_we_o     = (state_q == ST_WRITE);
  assign fill_phase_o = (state_q == ST_FILL);
  assign fill_sel_o   = cnt_q;
  // a refill ends in IDLE so the access is re-looked-up as a hit
  assign stall_o = (state_q == ST_FILL)
                || (state_q == ST_WRITE && !mem_ack_i)
                || (state_q == ST_IDLE && cpu_req_i && (!hit_i || cpu_we_i));

  // R5
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && mem_ack_i && !cnt_end) |=> (state_q == ST_FILL && cnt_q == $past(cnt_q) + 1'b1));
  // R8
  write_miss_fill_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && mem_ack_i && cnt_end && cpu_we_i) |=> (state_q == ST_IDLE && stall_o));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 12,
  parameter int WORDS  = 4,
  localparam int BOFF_W = $clog2(DATA_W / 8),
  localparam int SEL_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - SEL_W - BOFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [TAG_W-1:0]             a_tag;
  logic [IDX_W-1:0]             a_idx;
  logic [SEL_W-1:0]             a_sel;
  logic                         hit;
  logic [WORDS-1:0][DATA_W-1:0] line;
  logic                         fill_phase, fill_start, fill_wr, fill_last, wr_commit;
  logic [SEL_W-1:0]             fill_sel;

  assign a_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign a_idx = cpu_addr_i[BOFF_W+SEL_W +: IDX_W];
  assign a_sel = cpu_addr_i[BOFF_W +: SEL_W];

  cache_ctrl #(.WORDS(WORDS)) i_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i,
    .hit_i        (hit),
    .mem_ack_i,
    .stall_o      (cpu_stall_o),
    .mem_req_o, .mem_we_o,
    .fill_phase_o (fill_phase),
    .fill_sel_o   (fill_sel),
    .fill_start_o (fill_start),
    .fill_wr_o    (fill_wr),
    .fill_last_o  (fill_last),
    .wr_commit_o  (wr_commit)
  );

  cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORDS(WORDS), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .idx_i        (a_idx),
    .tag_i        (a_tag),
    .fill_start_i (fill_start),
    .fill_wr_i    (fill_wr),
    .fill_last_i  (fill_last),
    .fill_sel_i   (fill_sel),
    .fill_data_i  (mem_rdata_i),
    .wr_commit_i  (wr_commit),
    .wr_sel_i     (a_sel),
    .wr_data_i    (cpu_wdata_i),
    .hit_o        (hit),
    .line_o       (line)
  );

  cache_word_sel #(.WORDS(WORDS), .DATA_W(DATA_W)) i_sel (
    .line_i (line),
    .sel_i  (a_sel),
    .word_o (cpu_rdata_o)
  );

  assign mem_addr_o  = {a_tag, a_idx, (fill_phase ? fill_sel : a_sel), {BOFF_W{1'b0}}};
  assign mem_wdata_o = cpu_wdata_i;

  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R3
  read_hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && !cpu_stall_o) |-> !mem_req_o);
  // R7
  write_waits_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i) |-> cpu_stall_o);
  // R2
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mem_req_o);
endmodule

// File: tb/test_dm_wt_cache.sv
module test_dm_wt_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dm_wt_cache i_dm_wt_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_stall_o(cpu_stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model
  logic [31:0] wr_mem [logic [29:0]];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_log [8];
  logic [31:0] last_wr_addr, last_wr_data;
  bit          hold_bad = 1'b0;

  function automatic logic [31:0] model(input logic [31:0] a);
    if (wr_mem.exists(a[31:2])) return wr_mem[a[31:2]];
    return {a[31:2], 2'b00} ^ 32'hC3C3_0000;
  endfunction

  initial begin
    int          wait_n = 0;
    logic [31:0] held_addr = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req && rst_n) begin
        if (wait_n > 0 && mem_addr != held_addr) hold_bad = 1'b1;
        held_addr = mem_addr;
        wait_n++;
        if (wait_n == 3) begin
          mem_ack = 1'b1;
          wait_n  = 0;
          if (mem_we) begin
            wr_mem[mem_addr[31:2]] = mem_wdata;
            last_wr_addr = mem_addr;
            last_wr_data = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = model(mem_addr);
            rd_log[rd_cnt % 8] = mem_addr;
            rd_cnt++;
          end
        end
      end else wait_n = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int stall_cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #2;
    stall_cyc = 0;
    while (cpu_stall) begin
      @(negedge clk); #2;
      stall_cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0001_2348;
  localparam logic [31:0] B = 32'h0005_2348;
  localparam logic [31:0] C = 32'h0009_0010;

  task automatic t_reset;
    chk(!cpu_stall, "R2 stall after reset", {31'b0, cpu_stall}, 0);
    chk(!mem_req, "R2 mem_req after reset", {31'b0, mem_req}, 0);
  endtask

  task automatic t_read_miss;
    logic [31:0] rd; int sc; int r0 = rd_cnt;
    access(1'b0, A, '0, rd, sc);
    chk(rd_cnt - r0 == 4, "R5 refill word count", rd_cnt - r0, 4);
    for (int k = 0; k < 4; k++)
      chk(rd_log[(r0 + k) % 8] == {A[31:4], k[1:0], 2'b00}, "R5 refill order",
          rd_log[(r0 + k) % 8], {A[31:4], k[1:0], 2'b00});
    chk(sc > 0, "R2 first access misses", sc, 1);
    chk(rd == model(A), "R5 miss data", rd, model(A));
  endtask

  task automatic t_read_hits;
    logic [31:0] rd; int sc; int r0 = rd_cnt;
    access(1'b0, A, '0, rd, sc);
    chk(sc == 0 && rd == model(A), "R3 read hit", rd, model(A));
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a = {A[31:4], k[1:0], 2'b00};
      access(1'b0, a, '0, rd, sc);
      chk(sc == 0 && rd == model(a), "R4 word select", rd, model(a));
    end
    access(1'b0, A | 32'h3, '0, rd, sc);
    chk(sc == 0 && rd == model(A), "R10 byte offset ignored", rd, model(A));
    chk(rd_cnt == r0, "R3 no memory traffic on hit", rd_cnt - r0, 0);
  endtask

  task automatic t_conflict;
    logic [31:0] rd; int sc; int r0 = rd_cnt;
    access(1'b0, B, '0, rd, sc);
    chk(rd_cnt - r0 == 4 && rd == model(B), "R1 same index new tag misses", rd, model(B));
    access(1'b0, B, '0, rd, sc);
    chk(sc == 0 && rd == model(B), "R6 new tag resident", rd, model(B));
    r0 = rd_cnt;
    access(1'b0, A, '0, rd, sc);
    chk(rd_cnt - r0 == 4 && rd == model(A), "R6 old tag evicted", rd_cnt - r0, 4);
  endtask

  task automatic t_write_hit;
    logic [31:0] rd; int sc; int w0 = wr_cnt; int r0 = rd_cnt;
    access(1'b1, A | 32'h1, 32'hDEAD_BEEF, rd, sc);
    chk(wr_cnt - w0 == 1 && rd_cnt == r0, "R7 one write no refill", wr_cnt - w0, 1);
    chk(last_wr_addr == A, "R7 write address aligned", last_wr_addr, A);
    chk(last_wr_data == 32'hDEAD_BEEF, "R7 write data", last_wr_data, 32'hDEAD_BEEF);
    chk(sc > 0, "R7 stall until ack", sc, 1);
    access(1'b0, A, '0, rd, sc);
    chk(sc == 0 && rd == 32'hDEAD_BEEF, "R7 line updated", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd; int sc; int w0 = wr_cnt; int r0 = rd_cnt;
    logic [31:0] sib = C + 32'h4;
    logic [31:0] exp_sib = model(sib);
    access(1'b1, C, 32'h1234_5678, rd, sc);
    chk(rd_cnt - r0 == 4, "R8 refill before write", rd_cnt - r0, 4);
    chk(wr_cnt - w0 == 1 && last_wr_addr == C, "R8 write through", last_wr_addr, C);
    access(1'b0, sib, '0, rd, sc);
    chk(sc == 0 && rd == exp_sib, "R8 sibling from memory", rd, exp_sib);
    access(1'b0, C, '0, rd, sc);
    chk(sc == 0 && rd == 32'h1234_5678, "R8 written word", rd, 32'h1234_5678);
    chk(!hold_bad, "R9 request held stable", {31'b0, hold_bad}, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    t_reset;
    t_read_miss;
    t_read_hits;
    t_conflict;
    t_write_hit;
    t_write_miss;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run;
  end
endmodule